// File: doc/BRIEF.md
# Event Time and Count Accumulator

This block keeps a running record of how long an external activity signal has been asserted and how many activity periods have finished. A quarter-second strobe and a millisecond strobe come from outside, along with an activity level that is already synchronized and filtered. While an activity period is open and the level is high, an elapsed-time register advances by one on each quarter-second strobe. When the period ends, the elapsed value is committed to a persistent total and a period counter advances. A period ends on the level's high-to-low transition, or earlier when a power-fail strobe arrives.

The persistent total, the period count and the overflow flag survive the reset input. The reset input restarts only the working state. In the first cycle after reset the elapsed register is reloaded from the total. The total is rewritten one byte per cycle, least significant byte first, so the byte most likely to have changed lands first. The elapsed register stops at all-ones. The period count carries one extra sticky overflow bit and freezes once both have reached their limit. A bus-busy indication covers a fixed window after every change of the activity level. A clear strobe zeroes every accumulated value.

Top module: `evt_accum`

## Requirements
- R1: While reset is low, `elapsed` is 0 and `bus_busy` is 0, and `total`, `evt_count` and `evt_ovf` keep their values. On the first clock edge after reset is released, `elapsed` is loaded with `total`, and the activity level is not sampled on that edge.
- R2: After a rising level opens a period, `elapsed` rises by one on each clock edge where the level is high and `qtr_tick` is 1. It holds on every other edge, including the edge that sees the rise.
- R3: `elapsed` stops at all-ones and never wraps to zero.
- R4: A falling level on an open period commits the period. On that edge `evt_count` increments (subject to R6 and R7) and byte 0 of `total` takes byte 0 of `elapsed`. Byte k of `total` takes byte k of `elapsed` k edges later.
- R5: `pwr_fail` while a period is open commits the period as in R4 and closes it. Further ticks do not advance `elapsed` until a new rising level, and the following fall does not commit. `pwr_fail` with no open period changes nothing.
- R6: When `evt_count` is all-ones and `evt_ovf` is 0, a commit sets `evt_count` to 0 and `evt_ovf` to 1. `evt_ovf` then stays 1 until a clear.
- R7: When `evt_ovf` is 1 and `evt_count` is all-ones, commits leave `evt_count` unchanged. Time is still committed to `total`.
- R8: Every change of the activity level after the boot edge loads a window of BUSY_MS millisecond strobes. `bus_busy` is 1 from the edge that sees the change until BUSY_MS `ms_tick` strobes have passed.
- R9: `clear` zeroes `elapsed`, `total`, `evt_count` and `evt_ovf` on the same edge. It wins over a commit on that edge, and any byte write still in progress stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the working state |
| clear | input | 1 | Synchronous zeroing strobe for all accumulated values |
| qtr_tick | input | 1 | One-cycle quarter-second strobe |
| ms_tick | input | 1 | One-cycle millisecond strobe for the busy window |
| event_lvl | input | 1 | Synchronized, filtered activity level |
| pwr_fail | input | 1 | One-cycle power-loss strobe |
| elapsed | output | TIME_W | Elapsed quarter seconds of the running tally |
| total | output | TIME_W | Committed persistent total |
| evt_count | output | CNT_W | Completed-period count |
| evt_ovf | output | 1 | Sticky overflow bit of the period count |
| bus_busy | output | 1 | Serial bus unavailable after a level change |

## Verification
A corrupted open-period flag shows up on `elapsed` at the next tick: time advances when it should not, or stays flat while the level is high. It also shows up as a missing or doubled `evt_count` step at the next fall or power-fail strobe. A wrong byte index or a wrong staging value in the total writer appears on `total` within as many cycles as the total has bytes. This is why the bench samples `total` both on the commit edge and after it. A lost overflow bit is invisible until the count next reaches all-ones, so the bench drives the count through two full laps.

// File: rtl/evt_accum_pkg.sv
package evt_accum_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        PH_BOOT = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/evt_busy_timer.sv
module evt_busy_timer #(
    parameter int unsigned WIN = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ms_tick,
    output logic busy
);
    localparam int unsigned CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.left = CW'(WIN);
        end else if (ms_tick && tmr_q.left != '0) begin
            tmr_d.left = tmr_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = (tmr_q.left != '0);

endmodule

// File: rtl/evt_count_sat.sv
module evt_count_sat #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_s;

    cnt_s cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clear) begin
            cs_d = '0;
        end else if (bump) begin
            if (cs_q.cnt == '1) begin
                if (!cs_q.ovf) begin
                    cs_d.cnt = '0;
                    cs_d.ovf = 1'b1;
                end
            end else begin
                cs_d.cnt = cs_q.cnt + 1'b1;
            end
        end
    end

    // Persistent storage: survives the working-state reset.
    always_ff @(posedge clk) begin
        cs_q <= cs_d;
    end

    assign cnt = cs_q.cnt;
    assign ovf = cs_q.ovf;

endmodule

// File: rtl/evt_total_writer.sv
module evt_total_writer #(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              abort,
    input  logic              commit,
    input  logic [TIME_W-1:0] value,
    output logic [TIME_W-1:0] total
);
    import evt_accum_pkg::*;

    localparam int unsigned NBYTES = TIME_W / BYTE_W;
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        logic [TIME_W-1:0] total;
        logic [TIME_W-1:0] stage;
        logic [IDX_W-1:0]  idx;
        logic              active;
    } wr_s;

    wr_s wr_d, wr_q;

    always_comb begin
        wr_d = wr_q;
        if (clear) begin
            wr_d = '0;
        end else if (commit) begin
            wr_d.total[BYTE_W-1:0] = value[BYTE_W-1:0];
            wr_d.stage             = value;
            wr_d.idx               = IDX_W'(1);
            wr_d.active            = (NBYTES > 1);
        end else if (abort) begin
            wr_d.active = 1'b0;
        end else if (wr_q.active) begin
            wr_d.total[wr_q.idx*BYTE_W +: BYTE_W] = wr_q.stage[wr_q.idx*BYTE_W +: BYTE_W];
            wr_d.idx = wr_q.idx + 1'b1;
            if (wr_q.idx == IDX_W'(NBYTES - 1)) begin
                wr_d.active = 1'b0;
            end
        end
    end

    // Persistent storage: only clear zeroes it, reset merely aborts a write.
    always_ff @(posedge clk) begin
        wr_q <= wr_d;
    end

    assign total = wr_q.total;

endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
    parameter int unsigned TIME_W  = 32,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned BUSY_MS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              qtr_tick,
    input  logic              ms_tick,
    input  logic              event_lvl,
    input  logic              pwr_fail,
    output logic [TIME_W-1:0] elapsed,
    output logic [TIME_W-1:0] total,
    output logic [CNT_W-1:0]  evt_count,
    output logic              evt_ovf,
    output logic              bus_busy
);
    import evt_accum_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic              evt;
        logic              open;
        logic [TIME_W-1:0] elapsed;
    } acc_s;

    acc_s acc_d, acc_q;

    logic              run;
    logic              rise;
    logic              fall;
    logic              edge_seen;
    logic              commit;
    logic [TIME_W-1:0] total_w;

    always_comb begin
        run       = (acc_q.phase == PH_RUN);
        rise      = run &&  event_lvl && !acc_q.evt;
        fall      = run && !event_lvl &&  acc_q.evt;
        edge_seen = rise || fall;
        commit    = run && acc_q.open && (fall || pwr_fail);

        acc_d = acc_q;
        if (!run) begin
            acc_d.phase   = PH_RUN;
            acc_d.elapsed = total_w;
        end else begin
            acc_d.evt = event_lvl;
            if (rise) begin
                acc_d.open = 1'b1;
            end else if (commit) begin
                acc_d.open = 1'b0;
            end
            if (acc_q.open && event_lvl && qtr_tick && !pwr_fail && acc_q.elapsed != '1) begin
                acc_d.elapsed = acc_q.elapsed + 1'b1;
            end
        end
        if (clear) begin
            acc_d.elapsed = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '{phase: PH_BOOT, evt: 1'b0, open: 1'b0, elapsed: '0};
        end else begin
            acc_q <= acc_d;
        end
    end

    evt_total_writer #(.TIME_W(TIME_W)) u_writer (
        .clk    (clk),
        .clear  (clear),
        .abort  (!rst_n),
        .commit (commit),
        .value  (acc_q.elapsed),
        .total  (total_w)
    );

    evt_count_sat #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .clear (clear),
        .bump  (commit),
        .cnt   (evt_count),
        .ovf   (evt_ovf)
    );

    evt_busy_timer #(.WIN(BUSY_MS)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (edge_seen),
        .ms_tick (ms_tick),
        .busy    (bus_busy)
    );

    assign elapsed = acc_q.elapsed;
    assign total   = total_w;

endmodule

// File: rtl/evt_accum_chk.sv
module evt_accum_chk #(
    parameter int unsigned TIME_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              run,
    input logic              edge_seen,
    input logic              commit,
    input logic [TIME_W-1:0] elapsed,
    input logic [TIME_W-1:0] total,
    input logic [CNT_W-1:0]  evt_count,
    input logic              evt_ovf,
    input logic              bus_busy
);

    a_r2_elapsed_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && !$past(clear))
        |-> (elapsed == $past(elapsed) || elapsed == $past(elapsed) + 1'b1));

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run) && !$past(clear) && $past(elapsed) == '1)
        |-> (elapsed == '1));

    a_r4_count_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clear) && !$past(commit))
        |-> ($stable(evt_count) && $stable(evt_ovf)));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(evt_ovf) && !$past(clear)) |-> evt_ovf);

    a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(evt_ovf) && $past(evt_count) == '1 && !$past(clear))
        |-> (evt_count == '1));

    a_r8_busy_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> bus_busy);

    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clear))
        |-> (elapsed == '0 && total == '0 && evt_count == '0 && !evt_ovf));

endmodule

bind evt_accum evt_accum_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .run       (run),
    .edge_seen (edge_seen),
    .commit    (commit),
    .elapsed   (elapsed),
    .total     (total),
    .evt_count (evt_count),
    .evt_ovf   (evt_ovf),
    .bus_busy  (bus_busy)
);

// File: tb/evt_accum_bench.sv
`timescale 1ns/1ps
module evt_accum_bench;

    localparam int unsigned TW = 16;
    localparam int unsigned CW = 3;
    localparam int unsigned BW = 3;

    logic          clk = 1'b0;
    logic          rst_n, clear, qtr_tick, ms_tick, event_lvl, pwr_fail;
    logic [TW-1:0] elapsed, total;
    logic [CW-1:0] evt_count;
    logic          evt_ovf, bus_busy;

    always #10 clk = ~clk;

    evt_accum #(.TIME_W(TW), .CNT_W(CW), .BUSY_MS(BW)) u_evt_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .qtr_tick  (qtr_tick),
        .ms_tick   (ms_tick),
        .event_lvl (event_lvl),
        .pwr_fail  (pwr_fail),
        .elapsed   (elapsed),
        .total     (total),
        .evt_count (evt_count),
        .evt_ovf   (evt_ovf),
        .bus_busy  (bus_busy)
    );

    typedef struct {
        string         tag;
        logic [TW-1:0] el;
        logic [TW-1:0] tot;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          busy;
    } exp_t;

    exp_t          exp_q[$];
    int            n_vec  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;
    logic [TW-1:0] e_el   = '0;
    logic [TW-1:0] e_tot  = '0;
    logic [CW-1:0] e_cnt  = '0;
    logic          e_ovf  = 1'b0;

    task automatic cyc(input logic ev, input logic tk, input logic pf, input logic clr);
        @(negedge clk);
        event_lvl = ev;
        qtr_tick  = tk;
        pwr_fail  = pf;
        clear     = clr;
        @(posedge clk);
    endtask

    task automatic chk(input string tag, input logic busy);
        exp_t x;
        x.tag = tag; x.el = e_el; x.tot = e_tot; x.cnt = e_cnt; x.ovf = e_ovf; x.busy = busy;
        exp_q.push_back(x);
    endtask

    task automatic pulse();
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // Monitor: compares queued expectations shortly after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                n_vec++;
                if (elapsed !== x.el || total !== x.tot || evt_count !== x.cnt ||
                    evt_ovf !== x.ovf || bus_busy !== x.busy) begin
                    n_fail++;
                    $display("FAIL %s: got el=%h tot=%h cnt=%0d ovf=%b busy=%b, expected el=%h tot=%h cnt=%0d ovf=%b busy=%b",
                             x.tag, elapsed, total, evt_count, evt_ovf, bus_busy,
                             x.el, x.tot, x.cnt, x.ovf, x.busy);
                end
            end
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clear = 1'b1; qtr_tick = 1'b0; ms_tick = 1'b1;
        event_lvl = 1'b0; pwr_fail = 1'b0;
        repeat (3) @(posedge clk);
        chk("R1 reset state", 1'b0);
        @(negedge clk); rst_n = 1'b1; clear = 1'b0;
        @(posedge clk);
        chk("R1 boot load of zero total", 1'b0);

        // R8 busy window on a rising level
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 busy on rise", 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 busy last window cycle", 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 busy expired", 1'b0);

        // R2 counting
        for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        e_el = 16'd300;
        chk("R2 300 ticks", 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 hold without tick", 1'b0);

        // R4 commit on fall, low byte first
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        e_cnt = 3'd1; e_tot = 16'h002C;
        chk("R4 low byte on commit edge", 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        e_tot = 16'h012C;
        chk("R4 high byte one edge later", 1'b1);

        // R1 reset keeps persistent state, boot reloads elapsed
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        e_el = '0;
        chk("R1 reset keeps total and count", 1'b0);
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk);
        e_el = 16'h012C;
        chk("R1 boot reload from total", 1'b0);

        // R5 power-fail commit
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        e_el = 16'h0130; e_tot = 16'h0130; e_cnt = 3'd2;
        chk("R5 power-fail commits", 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5 closed period ignores tick", 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 fall after power-fail no commit", 1'b1);
        idle(4);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 power-fail without period ignored", 1'b0);

        // R9 clear wins over commit
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        e_el = '0; e_tot = '0; e_cnt = '0; e_ovf = 1'b0;
        chk("R9 clear with simultaneous fall", 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 no late byte write after clear", 1'b1);

        // R6 wrap into overflow bit
        for (int i = 0; i < 7; i++) pulse();
        idle(4);
        e_cnt = 3'd7;
        chk("R6 count at all-ones", 1'b0);
        pulse();
        idle(4);
        e_cnt = 3'd0; e_ovf = 1'b1;
        chk("R6 wrap sets overflow", 1'b0);
        for (int i = 0; i < 7; i++) pulse();
        idle(4);
        e_cnt = 3'd7;
        chk("R6 overflow stays set", 1'b0);

        // R7 frozen count, time still committed
        pulse();
        pulse();
        idle(4);
        chk("R7 count frozen", 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        idle(4);
        e_el = 16'd2; e_tot = 16'd2;
        chk("R7 total still committed", 1'b0);

        // R3 saturation
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        e_el = '0; e_tot = '0; e_cnt = '0; e_ovf = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 65538; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        e_el = 16'hFFFF;
        chk("R3 saturated at all-ones", 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        e_cnt = 3'd1; e_tot = 16'h00FF;
        chk("R4 saturated value low byte first", 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        e_tot = 16'hFFFF;
        chk("R4 saturated value complete", 1'b1);

        @(posedge clk);
        #5;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule